// File: doc/BRIEF.md
# Minimum Active-Dwell PWM Spacer

This block sits between a three-phase space-vector duty generator and the carrier comparator that follows it. At low modulation index the three duty words lie close together, so all three phase legs switch at almost the same instant. The common-mode current pulses from those edges then add up. The spacer moves the edges apart so that each of the two active states in a carrier period lasts at least a programmable number of counts. The zero states are left in place, so the peak common-mode voltage stays where it was. The spread of switching instants is the only thing that changes.

Each period the block adds a stored per-phase correction to the new duty command and clips the sum into the carrier range. It ranks the three phases, pushes the outer phases away from the middle one where the dwell limit requires it, and registers the result on the period strobe. Whatever it had to change, whether through the dwell push or through clipping, is stored as a signed error for that phase. That error is added to the next command, so the volt-seconds are paid back over the following periods. When the phases are already far enough apart and no error is pending, the duties pass through unchanged.

Top module: `dwell_spacer`

## Requirements
- R1: While `rst_n` is low, all three adjusted duties read 0 and every stored phase error is cleared. The first strobed period after reset therefore uses the raw commands.
- R2: The adjusted duties change only on a rising clock edge at which `period_stb` is high. Between strobes they hold, whatever the inputs do.
- R3: If the ranked targets already have gaps of at least the effective dwell and no error is pending, each output equals its input duty.
- R4: Each phase target (command plus stored error, clipped to 0..PERIOD) is ranked high, middle or low. On equal targets, u ranks above v and v ranks above w. The adjusted duties keep that order.
- R5: The middle target is first limited to the range [D, PERIOD−D], where D is the effective dwell. The high phase is then raised to at least middle+D and the low phase is lowered to at most middle−D. After this, every pair of adjusted duties differs by at least D.
- R6: Every adjusted duty lies in 0..PERIOD.
- R7: After each strobe, a phase's stored error equals its unclipped target minus its adjusted duty. That error is added to the phase's next command.
- R8: Stored errors saturate at the signed range of DW+2 bits (−2048..2047 with defaults) and never wrap.
- R9: A dwell request above PERIOD/2 acts as exactly PERIOD/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_stb | input | 1 | Carrier period boundary; loads new outputs |
| duty_u | input | DW | Phase u duty command, 0..PERIOD counts |
| duty_v | input | DW | Phase v duty command |
| duty_w | input | DW | Phase w duty command |
| min_dwell | input | DW | Requested minimum active-state length in counts |
| adj_u | output | DW | Adjusted phase u duty |
| adj_v | output | DW | Adjusted phase v duty |
| adj_w | output | DW | Adjusted phase w duty |

## Verification
The dwell push and the range clip can act on the same phase in the same period. This is provoked by driving one phase to the carrier limit with a neighbour only a few counts below it. The middle phase is then pulled inward while its payback target overshoots PERIOD. The result is judged on the period after that: the stored error must hold both the dwell shift and the clip residual, and this shows in the next outputs. Ties between phases and accumulator saturation are also provoked on purpose, and each is judged by the exact outputs of the periods that follow.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int NPH = 3;
    typedef logic [1:0] rank_t;
    localparam rank_t RANK_LO  = 2'd0;
    localparam rank_t RANK_MID = 2'd1;
    localparam rank_t RANK_HI  = 2'd2;
endpackage

// File: rtl/spc_rank.sv
module spc_rank #(
    parameter int DW = 10
) (
    input  logic [spc_pkg::NPH-1:0][DW-1:0] lvl,
    output spc_pkg::rank_t [spc_pkg::NPH-1:0] rank
);
    // rank = number of phases this one beats; lower index wins ties
    always_comb begin
        rank = '0;
        for (int i = 0; i < spc_pkg::NPH; i++) begin
            for (int j = 0; j < spc_pkg::NPH; j++) begin
                if (i != j) begin
                    if ((i < j) ? (lvl[i] >= lvl[j]) : (lvl[i] > lvl[j]))
                        rank[i] = rank[i] + 2'd1;
                end
            end
        end
    end

    always_comb begin
        assert (rank[0] != rank[1] && rank[1] != rank[2] && rank[0] != rank[2])
            else $error("assert_rank_unique_R4");
    end
endmodule

// File: rtl/spc_shape.sv
module spc_shape #(
    parameter int PERIOD = 1000,
    parameter int DW     = 10
) (
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] mid,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] dwell,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] mid_o,
    output logic [DW-1:0] lo_o
);
    localparam logic [DW-1:0] PMAX = DW'(PERIOD);

    logic [DW-1:0] mid_cap;

    always_comb begin
        // middle phase kept far enough from both carrier ends
        mid_cap = PMAX - dwell;
        if (mid < dwell)
            mid_o = dwell;
        else if (mid > mid_cap)
            mid_o = mid_cap;
        else
            mid_o = mid;
        hi_o = (hi < mid_o + dwell) ? mid_o + dwell : hi;
        lo_o = (lo > mid_o - dwell) ? mid_o - dwell : lo;
    end

    always_comb begin
        assert (hi_o >= hi && lo_o <= lo) else $error("assert_outward_push_R5");
    end
endmodule

// File: rtl/dwell_spacer.sv
module dwell_spacer #(
    parameter int PERIOD = 1000,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_stb,
    input  logic [DW-1:0] duty_u,
    input  logic [DW-1:0] duty_v,
    input  logic [DW-1:0] duty_w,
    input  logic [DW-1:0] min_dwell,
    output logic [DW-1:0] adj_u,
    output logic [DW-1:0] adj_v,
    output logic [DW-1:0] adj_w
);
    import spc_pkg::*;

    localparam int EW      = DW + 2;
    localparam int TW      = EW + 1;
    localparam int HALF    = PERIOD / 2;
    localparam int ACC_MAX = 2 ** (EW - 1) - 1;
    localparam int ACC_MIN = -(2 ** (EW - 1));

    typedef struct packed {
        logic [NPH-1:0][DW-1:0] adj;
        logic [NPH-1:0][EW-1:0] acc;
    } state_t;

    state_t state_d, state_q;

    logic [NPH-1:0][DW-1:0] duty;
    logic signed [TW-1:0]   tgt  [NPH];
    logic signed [TW-1:0]   err  [NPH];
    logic [NPH-1:0][DW-1:0] clip;
    logic [NPH-1:0][DW-1:0] shaped;
    rank_t [NPH-1:0]        rank;
    logic [DW-1:0]          dwell_eff;
    logic [DW-1:0]          s_hi, s_mid, s_lo, o_hi, o_mid, o_lo;

    assign duty      = {duty_w, duty_v, duty_u};
    assign dwell_eff = (min_dwell > DW'(HALF)) ? DW'(HALF) : min_dwell;

    // per-phase target: command plus carried error, clipped into the carrier range
    for (genvar p = 0; p < NPH; p++) begin : g_tgt
        always_comb begin
            tgt[p] = $signed({{(TW-DW){1'b0}}, duty[p]}) + TW'($signed(state_q.acc[p]));
            if (tgt[p] < 0)
                clip[p] = '0;
            else if (tgt[p] > PERIOD)
                clip[p] = DW'(PERIOD);
            else
                clip[p] = tgt[p][DW-1:0];
        end
    end

    spc_rank #(.DW(DW)) u_rank (
        .lvl  (clip),
        .rank (rank)
    );

    always_comb begin
        s_hi = '0; s_mid = '0; s_lo = '0;
        for (int p = 0; p < NPH; p++) begin
            if (rank[p] == RANK_HI)  s_hi  = clip[p];
            if (rank[p] == RANK_MID) s_mid = clip[p];
            if (rank[p] == RANK_LO)  s_lo  = clip[p];
        end
    end

    spc_shape #(.PERIOD(PERIOD), .DW(DW)) u_shape (
        .hi    (s_hi),
        .mid   (s_mid),
        .lo    (s_lo),
        .dwell (dwell_eff),
        .hi_o  (o_hi),
        .mid_o (o_mid),
        .lo_o  (o_lo)
    );

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < NPH; p++) begin
            case (rank[p])
                RANK_HI:  shaped[p] = o_hi;
                RANK_MID: shaped[p] = o_mid;
                default:  shaped[p] = o_lo;
            endcase
            err[p] = tgt[p] - $signed({{(TW-DW){1'b0}}, shaped[p]});
            if (period_stb) begin
                state_d.adj[p] = shaped[p];
                if (err[p] > ACC_MAX)
                    state_d.acc[p] = EW'(ACC_MAX);
                else if (err[p] < ACC_MIN)
                    state_d.acc[p] = EW'(ACC_MIN);
                else
                    state_d.acc[p] = err[p][EW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign adj_u = state_q.adj[0];
    assign adj_v = state_q.adj[1];
    assign adj_w = state_q.adj[2];

    function automatic logic [DW-1:0] gap(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a >= b) ? a - b : b - a;
    endfunction

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !period_stb |=> $stable({adj_u, adj_v, adj_w}));

    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adj_u <= DW'(PERIOD) && adj_v <= DW'(PERIOD) && adj_w <= DW'(PERIOD));

    assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> (gap(adj_u, adj_v) >= $past(dwell_eff)) &&
                       (gap(adj_v, adj_w) >= $past(dwell_eff)) &&
                       (gap(adj_u, adj_w) >= $past(dwell_eff)));

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> (!$past(clip[0] >= clip[1]) || adj_u >= adj_v) &&
                       (!$past(clip[1] >= clip[2]) || adj_v >= adj_w) &&
                       (!$past(clip[0] >= clip[2]) || adj_u >= adj_w));

    assert_dwell_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_eff <= DW'(HALF));
endmodule

// File: tb/dwell_spacer_bench.sv
`timescale 1ns/1ps
module dwell_spacer_bench;
    localparam int PERIOD = 1000;
    localparam int DW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_stb = 1'b0;
    logic [DW-1:0] duty_u = '0, duty_v = '0, duty_w = '0, min_dwell = '0;
    logic [DW-1:0] adj_u, adj_v, adj_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dwell_spacer #(.PERIOD(PERIOD), .DW(DW)) u_dwell_spacer (
        .clk(clk), .rst_n(rst_n), .period_stb(period_stb),
        .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w), .min_dwell(min_dwell),
        .adj_u(adj_u), .adj_v(adj_v), .adj_w(adj_w)
    );

    // du, dv, dw, dwell, expected u, v, w  (sequence from reset, errors carry)
    localparam int NV = 10;
    localparam int VEC [0:NV-1][0:6] = '{
        '{ 600,  400, 200,   50,  600,  400,  200},  // R3 pass-through
        '{ 510,  500, 490,   50,  550,  500,  450},  // R5 push outward
        '{ 300,  700, 500,   50,  260,  700,  540},  // R7 payback
        '{ 500,  500, 500,  100,  600,  500,  400},  // R4 tie u>v>w
        '{ 500,  500, 500,    0,  400,  500,  600},  // R7 payback of tie
        '{1000,  990,   5,   40, 1000,  960,    5},  // R5 mid capped
        '{1000,  990,   5,   40, 1000,  960,    5},  // R6 clip + R4 tie at top
        '{ 500,  500, 500,    0,  500,  560,  500},  // R7 residual paid
        '{ 500,  500, 500, 1023, 1000,  500,    0},  // R9 dwell capped
        '{ 500,  500, 500,    0,    0,  500, 1000}   // R7 payback of cap
    };

    task automatic check(input string req, input int eu, input int ev, input int ew);
        n_chk++;
        if (adj_u != eu || adj_v != ev || adj_w != ew) begin
            n_bad++;
            $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, adj_u, adj_v, adj_w, eu, ev, ew);
        end
    endtask

    task automatic apply(input int du, input int dv, input int dw, input int d);
        @(negedge clk);
        duty_u = DW'(du); duty_v = DW'(dv); duty_w = DW'(dw); min_dwell = DW'(d);
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 0, 0, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3]);
            check($sformatf("R3/R4/R5/R6/R7/R9 vector %0d", k), VEC[k][4], VEC[k][5], VEC[k][6]);
        end

        // R2: inputs move without a strobe, outputs must hold
        @(negedge clk);
        duty_u = 10; duty_v = 20; duty_w = 30; min_dwell = 200;
        repeat (4) @(negedge clk);
        check("R2 hold without strobe", 0, 500, 1000);

        // R1: reset in the middle of a run clears stored errors
        repeat (6) apply(0, 0, 0, 500);
        check("R5 all-zero spread", 1000, 500, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 0, 0, 0);
        rst_n = 1'b1;
        apply(1000, 1000, 1000, 0);
        check("R1 errors cleared", 1000, 1000, 1000);

        // R8: errors saturate at -2048 instead of wrapping
        repeat (6) apply(0, 0, 0, 500);
        apply(1000, 1000, 1000, 0);
        check("R8 saturated step 1", 0, 0, 1000);
        apply(1000, 1000, 1000, 0);
        check("R8 saturated step 2", 0, 0, 1000);
        apply(1000, 1000, 1000, 0);
        check("R8 saturated step 3", 952, 952, 1000);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule